// File: doc/BRIEF.md
# Spare-Subarray Row Remapper

This block sits between the row address source and the wordline decoders of a memory split into several normal subarrays plus one dedicated spare subarray. The normal subarrays carry no spare rows. Every spare row lives in the spare subarray, and each spare row has its own entry holding a full defective address (subarray number and row within it) and a valid bit. Any spare row can stand in for a defective row in any normal subarray. A cluster of faults inside a single subarray can therefore use every spare at once.

Lookups arrive on a valid/ready stream. Each result leaves on a registered valid/ready stream one cycle later. A result names the subarray to activate, the row within it, and a flag telling whether the access was moved. When an address matches a valid entry, the access leaves its normal subarray entirely. The result names subarray number `NSUB` (the spare subarray) and the row equal to the matching entry's index. The spare row count `NSPARE` is independent of the normal subarray depth `ROWS`.

The back-pressure rules are as follows. A lookup is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds still. A plain write port loads entries. A plain status pin reports when two valid entries hold the same address.

Top module: `spare_row_remap`

## Requirements
- R1: After reset, `out_valid` and `dup_err` are 0, `in_ready` is 1, and every entry is invalid, so every lookup misses.
- R2: On a miss, the result copies the input address (`out_sub` = `in_sub`, `out_row` = `in_row`) and `out_hit` is 0.
- R3: On a hit, `out_sub` equals `NSUB` (the spare subarray), `out_row` equals the matching entry index, and `out_hit` is 1.
- R4: An entry written with `cfg_valid` = 0 never produces a hit, even when its stored address equals the lookup address.
- R5: The comparison covers both the subarray and the row bits. The same row in a different subarray misses.
- R6: All `NSPARE` entries may hold rows of one and the same normal subarray, and each of those rows is remapped to its own spare row.
- R7: When two valid entries hold the same address, `dup_err` is 1 and a lookup of that address hits the lowest-indexed such entry. `dup_err` returns to 0 once the duplicate is removed.
- R8: A configuration write whose `cfg_idx` is `NSPARE` or larger changes no entry.
- R9: A lookup accepted at one edge is presented on `out_*` just after that edge. `in_ready` = !`out_valid` | `out_ready`. While `out_valid` & !`out_ready`, the outputs stay unchanged and no new lookup is taken.
- R10: A configuration write affects lookups accepted at later edges. A lookup accepted at the same edge as a write sees the old entry contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lookup request valid |
| in_ready | output | 1 | Lookup can be accepted |
| in_sub | input | SUB_W | Normal subarray number of the lookup |
| in_row | input | ROW_W | Row within the subarray |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_sub | output | SUB_W | Subarray to activate (`NSUB` means spare) |
| out_row | output | OROW_W | Row to activate within that subarray |
| out_hit | output | 1 | Access was remapped to the spare subarray |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry (spare row) to write |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_sub | input | SUB_W | Defective subarray number to store |
| cfg_row | input | ROW_W | Defective row to store |
| dup_err | output | 1 | Two valid entries hold the same address |

## Verification
The hardest case to reach from the ports is a lookup accepted at the same edge as a write to the entry it would match. The bench drives the write strobe and the request in the same cycle and expects the old contents, then repeats the lookup and expects the new ones. The stalled output stage is also hard to reach: the bench holds `out_ready` low with a second request waiting, and confirms that the first result stays put and that the second is taken only when the stall clears. Every entry table the bench loads is then swept over every address of a small configuration, with the expected result computed from a model of the table.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic {ROUTE_NORMAL = 1'b0, ROUTE_SPARE = 1'b1} route_e;

  function automatic int wmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/remap_entry_bank.sv
module remap_entry_bank #(
  parameter int NSPARE = 5,
  parameter int SUB_W  = 4,
  parameter int ROW_W  = 6,
  parameter int IDX_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic                      wr_vld,
  input  logic [SUB_W-1:0]          wr_sub,
  input  logic [ROW_W-1:0]          wr_row,
  output logic [NSPARE-1:0]         ent_vld,
  output logic [NSPARE*SUB_W-1:0]   ent_sub,
  output logic [NSPARE*ROW_W-1:0]   ent_row
);
  for (genvar g = 0; g < NSPARE; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[g]                 <= 1'b0;
        ent_sub[g*SUB_W +: SUB_W]  <= '0;
        ent_row[g*ROW_W +: ROW_W]  <= '0;
      end else if (sel) begin
        ent_vld[g]                 <= wr_vld;
        ent_sub[g*SUB_W +: SUB_W]  <= wr_sub;
        ent_row[g*ROW_W +: ROW_W]  <= wr_row;
      end
    end
  end

  // R8
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) >= NSPARE) |=>
      ($stable(ent_vld) && $stable(ent_sub) && $stable(ent_row)));
endmodule

// File: rtl/remap_match.sv
module remap_match #(
  parameter int NSPARE = 5,
  parameter int SUB_W  = 4,
  parameter int ROW_W  = 6,
  parameter int IDX_W  = 3
) (
  input  logic [SUB_W-1:0]          q_sub,
  input  logic [ROW_W-1:0]          q_row,
  input  logic [NSPARE-1:0]         ent_vld,
  input  logic [NSPARE*SUB_W-1:0]   ent_sub,
  input  logic [NSPARE*ROW_W-1:0]   ent_row,
  output logic                      hit,
  output logic [IDX_W-1:0]          hit_idx
);
  logic [NSPARE-1:0] raw;

  for (genvar g = 0; g < NSPARE; g++) begin : g_cmp
    assign raw[g] = ent_vld[g]
                 && (ent_sub[g*SUB_W +: SUB_W] == q_sub)
                 && (ent_row[g*ROW_W +: ROW_W] == q_row);
  end

  // lowest index wins: scan downward so the last assignment is the smallest
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NSPARE - 1; i >= 0; i--) begin
      if (raw[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/remap_dup_check.sv
module remap_dup_check #(
  parameter int NSPARE = 5,
  parameter int SUB_W  = 4,
  parameter int ROW_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSPARE-1:0]         ent_vld,
  input  logic [NSPARE*SUB_W-1:0]   ent_sub,
  input  logic [NSPARE*ROW_W-1:0]   ent_row,
  output logic                      dup
);
  localparam int NPAIR = (NSPARE * (NSPARE - 1)) / 2 + 1;
  logic [NPAIR-1:0] pair_eq;

  for (genvar i = 0; i < NSPARE; i++) begin : g_a
    for (genvar j = i + 1; j < NSPARE; j++) begin : g_b
      localparam int P = i * NSPARE - (i * (i + 1)) / 2 + (j - i - 1);
      assign pair_eq[P] = ent_vld[i] && ent_vld[j]
                       && (ent_sub[i*SUB_W +: SUB_W] == ent_sub[j*SUB_W +: SUB_W])
                       && (ent_row[i*ROW_W +: ROW_W] == ent_row[j*ROW_W +: ROW_W]);
    end
  end
  assign pair_eq[NPAIR-1] = 1'b0;

  assign dup = |pair_eq;

  // R7
  dup_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup |-> ($countones(ent_vld) >= 2));
endmodule

// File: rtl/spare_row_remap.sv
module spare_row_remap #(
  parameter int NSUB   = 8,
  parameter int ROWS   = 64,
  parameter int NSPARE = 5,
  localparam int SUB_W  = $clog2(NSUB + 1),
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int IDX_W  = (NSPARE > 1) ? $clog2(NSPARE) : 1,
  localparam int OROW_W = remap_pkg::wmax(ROW_W, IDX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SUB_W-1:0]  in_sub,
  input  logic [ROW_W-1:0]  in_row,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SUB_W-1:0]  out_sub,
  output logic [OROW_W-1:0] out_row,
  output logic              out_hit,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [SUB_W-1:0]  cfg_sub,
  input  logic [ROW_W-1:0]  cfg_row,
  output logic              dup_err
);
  import remap_pkg::*;

  logic [NSPARE-1:0]       ent_vld;
  logic [NSPARE*SUB_W-1:0] ent_sub;
  logic [NSPARE*ROW_W-1:0] ent_row;
  logic                    m_hit;
  logic [IDX_W-1:0]        m_idx;
  route_e                  route;
  logic [SUB_W-1:0]        nx_sub;
  logic [OROW_W-1:0]       nx_row;
  logic                    take;

  remap_entry_bank #(.NSPARE(NSPARE), .SUB_W(SUB_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_vld(cfg_valid),
    .wr_sub(cfg_sub), .wr_row(cfg_row),
    .ent_vld(ent_vld), .ent_sub(ent_sub), .ent_row(ent_row));

  remap_match #(.NSPARE(NSPARE), .SUB_W(SUB_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_match (
    .q_sub(in_sub), .q_row(in_row),
    .ent_vld(ent_vld), .ent_sub(ent_sub), .ent_row(ent_row),
    .hit(m_hit), .hit_idx(m_idx));

  remap_dup_check #(.NSPARE(NSPARE), .SUB_W(SUB_W), .ROW_W(ROW_W)) u_dup (
    .clk(clk), .rst_n(rst_n),
    .ent_vld(ent_vld), .ent_sub(ent_sub), .ent_row(ent_row),
    .dup(dup_err));

  assign route    = m_hit ? ROUTE_SPARE : ROUTE_NORMAL;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    if (route == ROUTE_SPARE) begin
      nx_sub = SUB_W'(NSUB);
      nx_row = OROW_W'(m_idx);
    end else begin
      nx_sub = in_sub;
      nx_row = OROW_W'(in_row);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sub   <= '0;
      out_row   <= '0;
      out_hit   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_sub   <= nx_sub;
      out_row   <= nx_row;
      out_hit   <= (route == ROUTE_SPARE);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_sub) && $stable(out_row) && $stable(out_hit)));

  // R9
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R3
  hit_to_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (out_sub == SUB_W'(NSUB)));

  // R2
  miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !m_hit) |=>
      (!out_hit && out_sub == $past(in_sub) && out_row == OROW_W'($past(in_row))));

  // R4
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_hit |-> ent_vld[m_idx]);
endmodule

// File: tb/sim_spare_row_remap.sv
module sim_spare_row_remap;
  localparam int NSUB = 4, ROWS = 8, NSPARE = 3;
  localparam int SUB_W = 3, ROW_W = 3, IDX_W = 2, OROW_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [SUB_W-1:0] in_sub = '0;
  logic [ROW_W-1:0] in_row = '0;
  logic in_ready, out_valid, out_hit, dup_err;
  logic [SUB_W-1:0] out_sub;
  logic [OROW_W-1:0] out_row;
  logic cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [SUB_W-1:0] cfg_sub = '0;
  logic [ROW_W-1:0] cfg_row = '0;

  int vecs = 0, bad = 0;
  bit m_vld[NSPARE];
  int m_sub[NSPARE], m_row[NSPARE];

  always #5 clk = ~clk;

  spare_row_remap #(.NSUB(NSUB), .ROWS(ROWS), .NSPARE(NSPARE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sub(in_sub), .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready),
    .out_sub(out_sub), .out_row(out_row), .out_hit(out_hit),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_sub(cfg_sub), .cfg_row(cfg_row), .dup_err(dup_err));

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_of(input int s, input int r);
    for (int i = 0; i < NSPARE; i++)
      if (m_vld[i] && m_sub[i] == s && m_row[i] == r)
        return (1 << 8) | (NSUB << 4) | i;
    return (s << 4) | r;
  endfunction

  function automatic int got();
    return (int'(out_hit) << 8) | (int'(out_sub) << 4) | int'(out_row);
  endfunction

  task automatic look(input int s, input int r, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_sub = SUB_W'(s); in_row = ROW_W'(r);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, int'(out_valid), 1);
    chk(tag, got(), expect_of(s, r));
  endtask

  task automatic wr(input int idx, input bit v, input int s, input int r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_valid = v;
    cfg_sub = SUB_W'(s); cfg_row = ROW_W'(r);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < NSPARE) begin m_vld[idx] = v; m_sub[idx] = s; m_row[idx] = r; end
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < NSUB; s++)
      for (int r = 0; r < ROWS; r++)
        look(s, r, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSPARE; i++) begin m_vld[i] = 0; m_sub[i] = 0; m_row[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 dup_err", int'(dup_err), 0);
    sweep("R1/R2 empty table");

    // R3 R4 R5: same row in two subarrays, one invalid entry at a swept address
    wr(0, 1, 1, 3);
    wr(1, 1, 2, 3);
    wr(2, 0, 0, 0);
    sweep("R3/R4/R5 mixed table");

    // R6: cluster of faults in one subarray
    wr(0, 1, 3, 0);
    wr(1, 1, 3, 5);
    wr(2, 1, 3, 7);
    sweep("R6 clustered");

    // R8: out-of-range index must change nothing
    wr(3, 1, 0, 1);
    sweep("R8 oob write");
    chk("R8 dup_err", int'(dup_err), 0);

    // R7: duplicate address, lowest entry wins
    wr(0, 1, 2, 2);
    wr(2, 1, 2, 2);
    chk("R7 dup_err set", int'(dup_err), 1);
    look(2, 2, "R7 lowest wins");
    wr(0, 0, 2, 2);
    chk("R7 dup_err clear", int'(dup_err), 0);
    look(2, 2, "R7 after removal");

    // R10: write and lookup at the same edge sees old contents
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd1; cfg_valid = 1'b1; cfg_sub = 3'd0; cfg_row = 3'd6;
    in_valid = 1'b1; in_sub = 3'd0; in_row = 3'd6;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R10 same-edge old", got(), expect_of(0, 6));
    m_vld[1] = 1; m_sub[1] = 0; m_row[1] = 6;
    look(0, 6, "R10 later new");

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_sub = 3'd0; in_row = 3'd6;
    @(posedge clk);
    @(negedge clk);
    in_sub = 3'd1; in_row = 3'd4;
    chk("R9 in_ready low", int'(in_ready), 0);
    chk("R9 first out", got(), expect_of(0, 6));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 held valid", int'(out_valid), 1);
    chk("R9 held data", got(), expect_of(0, 6));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second valid", int'(out_valid), 1);
    chk("R9 second out", got(), expect_of(1, 4));
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", int'(out_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule